// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Front End

This block is the bus-facing half of a 2 Kbyte serial EEPROM. A system clock oversamples the two-wire clock and data lines. The block finds start and stop conditions and checks the device-select byte, which carries the three high address bits. For a write it takes in the low address byte and hands each following data byte to a page write controller, together with its 11-bit address. For a read it shifts bytes out of the memory array, most significant bit first, and steps its address counter after every byte.

The data line is driven only through an open-drain enable, and that enable is asserted only to pull the line low. While the memory reports a write cycle in progress, the block does not acknowledge its device-select byte. A master can therefore poll for completion by repeating the select until an acknowledge returns. A read goes on for as long as the master acknowledges each byte. When no acknowledge comes, the block releases the line and ignores the bus until the next start or stop.

The controller is one state machine with ten states. ST_IDLE waits for a start. ST_DEV shifts in the select byte, then goes to ST_DEV_ACK on a match or to ST_WAIT_STOP on a mismatch or while the memory is busy. ST_DEV_ACK goes to ST_RDATA for a read or to ST_WADDR for a write. ST_WADDR goes to ST_WADDR_ACK and then to ST_WDATA. ST_WDATA and ST_WDATA_ACK alternate, one pair per data byte. ST_RDATA goes to ST_RD_ACK, which returns to ST_RDATA if the master acknowledged and otherwise goes to ST_WAIT_STOP. A start moves the machine from any state to ST_DEV, and a stop moves it from any state to ST_IDLE.

Top module: `ees_slave`

## Requirements
- R1: A falling SDA while SCL is high is a start and moves the machine to select-byte reception from any state. A rising SDA while SCL is high is a stop and returns the machine to idle. A byte clocked after a stop, with no new start, gets no acknowledge.
- R2: The select byte is acknowledged only when its upper four bits (bits 7..4) equal 1010. Otherwise the block drives nothing until the next start or stop.
- R3: While mem_busy_i is high, no select byte is acknowledged. Once mem_busy_i is low again, the same select byte is acknowledged.
- R4: A matching select byte, the word-address byte and each write data byte are acknowledged by pulling SDA low for the whole ninth clock.
- R5: In a write, the select byte's bits 3..1 give A10..A8 and the next byte gives A7..A0. Each later data byte gives one wr_valid_o pulse carrying that byte and the current address. The address then increases by one.
- R6: A stop that ends a write in which at least one data byte was received gives exactly one wr_end_o pulse.
- R7: A random read, made of a write of select and word address followed by a repeated start and a select with bit 0 set, returns the byte at that address MSB first.
- R8: The address counter goes up by one after every byte read or written, and it wraps from 0x7FF to 0x000.
- R9: A read byte that the master does not acknowledge ends the read. SDA is released and stays released for any further clocks until a start or stop.
- R10: The address counter keeps its value between transfers, so a read with no address phase (current-address read) starts where the last access left off.
- R11: sda_oe_o is low after reset and changes only while SCL is low. Its only use is to pull the line low.
- R12: SCL and SDA pass through two synchroniser flops each, so an acknowledge drive appears on the third clock edge after SCL falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Two-wire bus clock line level |
| sda_i | input | 1 | Two-wire bus data line level |
| sda_oe_o | output | 1 | Open-drain enable; high pulls SDA low |
| mem_busy_i | input | 1 | Memory write cycle in progress |
| rd_addr_o | output | 11 | Address counter, used as read address |
| rd_data_i | input | 8 | Array byte at rd_addr_o, same cycle |
| wr_valid_o | output | 1 | One-cycle strobe for a received data byte |
| wr_addr_o | output | 11 | Address of the strobed data byte |
| wr_data_o | output | 8 | Strobed data byte |
| wr_end_o | output | 1 | One-cycle pulse at stop after write data |

## Verification
An SCL edge is seen by the block three system clocks after the pin moves: two cycles in the synchronisers and one in the state register. The bench keeps every line level for twenty cycles, samples SDA in the middle of each SCL high phase, and measures the delay from the last data fall to the acknowledge drive, which must be exactly three cycles. Write strobes are logged on the falling clock edge as they happen. The write log and the end-of-write pulse count are compared only after the stop has been held for twenty cycles, well past the three-cycle stop detection.

// File: rtl/ees_pkg.sv
package ees_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RD_ACK,
        ST_WAIT_STOP
    } ees_state_t;

    localparam logic [3:0] DEV_CODE = 4'b1010;
    localparam int         BYTE_W   = 8;
endpackage

// File: rtl/ees_line_cond.sv
module ees_line_cond #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_prv;
    logic              sda_prv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff  <= '1;
            sda_ff  <= '1;
            scl_prv <= 1'b1;
            sda_prv <= 1'b1;
        end else begin
            scl_ff  <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff  <= {sda_ff[STAGES-2:0], sda_i};
            scl_prv <= scl_s;
            sda_prv <= sda_s;
        end
    end

    assign scl_s    = scl_ff[STAGES-1];
    assign sda_s    = sda_ff[STAGES-1];
    assign scl_rise = !scl_prv && scl_s;
    assign scl_fall = scl_prv && !scl_s;
    assign start_p  = scl_prv && scl_s && sda_prv && !sda_s;
    assign stop_p   = scl_prv && scl_s && !sda_prv && sda_s;
endmodule

// File: rtl/ees_addr_ctr.sv
module ees_addr_ctr #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_hi,
    input  logic [AW-9:0] hi_val,
    input  logic          ld_lo,
    input  logic [7:0]    lo_val,
    input  logic          inc,
    output logic [AW-1:0] cnt
);
    localparam logic [AW-1:0] MAX_ADDR = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (ld_hi) cnt <= {hi_val, cnt[7:0]};
        else if (ld_lo) cnt <= {cnt[AW-1:8], lo_val};
        else if (inc)   cnt <= cnt + 1'b1;
    end

    AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !ld_hi && !ld_lo && cnt == MAX_ADDR) |=> (cnt == '0)); // R8
endmodule

// File: rtl/ees_slave.sv
module ees_slave
    import ees_pkg::*;
#(
    parameter int AW      = 11,
    parameter int SYNC_FF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe_o,
    input  logic          mem_busy_i,
    output logic [AW-1:0] rd_addr_o,
    input  logic [7:0]    rd_data_i,
    output logic          wr_valid_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [7:0]    wr_data_o,
    output logic          wr_end_o
);
    localparam int          HIW      = AW - BYTE_W;
    localparam logic [3:0]  BITS_END = 4'd8;

    ees_state_t  state, nxt;
    logic        scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
    logic [7:0]  shreg;
    logic [7:0]  txreg;
    logic [3:0]  bitcnt;
    logic        dev_rw;
    logic        mack;
    logic        wrote;
    logic        byte_done;
    logic        dev_match;
    logic        ld_hi, ld_lo, inc;
    logic [AW-1:0] addr;

    ees_line_cond #(.STAGES(SYNC_FF)) i_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p)
    );

    ees_addr_ctr #(.AW(AW)) i_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_hi  (ld_hi),
        .hi_val (shreg[HIW:1]),
        .ld_lo  (ld_lo),
        .lo_val (shreg),
        .inc    (inc),
        .cnt    (addr)
    );

    assign byte_done = scl_fall && (bitcnt == BITS_END);
    assign dev_match = (shreg[7:4] == DEV_CODE);

    // address counter control, gated off on bus conditions
    always_comb begin
        ld_hi = 1'b0;
        ld_lo = 1'b0;
        inc   = 1'b0;
        if (!start_p && !stop_p) begin
            ld_hi = (state == ST_DEV) && byte_done && dev_match && !mem_busy_i && !shreg[0];
            ld_lo = (state == ST_WADDR) && byte_done;
            inc   = ((state == ST_WDATA) || (state == ST_RDATA)) && byte_done;
        end
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (start_p) begin
            nxt = ST_DEV;
        end else if (stop_p) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_DEV:       if (byte_done) nxt = (dev_match && !mem_busy_i) ? ST_DEV_ACK : ST_WAIT_STOP;
                ST_DEV_ACK:   if (scl_fall)  nxt = dev_rw ? ST_RDATA : ST_WADDR;
                ST_WADDR:     if (byte_done) nxt = ST_WADDR_ACK;
                ST_WADDR_ACK: if (scl_fall)  nxt = ST_WDATA;
                ST_WDATA:     if (byte_done) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall)  nxt = ST_WDATA;
                ST_RDATA:     if (byte_done) nxt = ST_RD_ACK;
                ST_RD_ACK:    if (scl_fall)  nxt = mack ? ST_RDATA : ST_WAIT_STOP;
                ST_WAIT_STOP: nxt = ST_WAIT_STOP;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg      <= '0;
            txreg      <= '0;
            bitcnt     <= '0;
            dev_rw     <= 1'b0;
            mack       <= 1'b0;
            wrote      <= 1'b0;
            wr_valid_o <= 1'b0;
            wr_addr_o  <= '0;
            wr_data_o  <= '0;
            wr_end_o   <= 1'b0;
        end else begin
            wr_valid_o <= 1'b0;
            wr_end_o   <= 1'b0;
            if (start_p) begin
                bitcnt <= '0;
            end else if (stop_p) begin
                wr_end_o <= wrote;
                wrote    <= 1'b0;
            end else begin
                unique case (state)
                    ST_DEV, ST_WADDR, ST_WDATA: begin
                        if (scl_rise && bitcnt < BITS_END) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (byte_done) begin
                            bitcnt <= '0;
                            if (state == ST_DEV) dev_rw <= shreg[0];
                            if (state == ST_WDATA) begin
                                wr_valid_o <= 1'b1;
                                wr_addr_o  <= addr;
                                wr_data_o  <= shreg;
                                wrote      <= 1'b1;
                            end
                        end
                    end
                    ST_DEV_ACK: begin
                        if (scl_fall && dev_rw) txreg <= rd_data_i;
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall) begin
                            if (bitcnt == BITS_END) bitcnt <= '0;
                            else                    txreg  <= {txreg[6:0], 1'b1};
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise)              mack  <= !sda_s;
                        else if (scl_fall && mack) txreg <= rd_data_i;
                    end
                    default: ;
                endcase
            end
        end
    end

    // open-drain output: drive low for acknowledges and zero read bits
    always_comb begin
        unique case (state)
            ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: sda_oe_o = 1'b1;
            ST_RDATA:                               sda_oe_o = !txreg[7];
            default:                                sda_oe_o = 1'b0;
        endcase
    end

    assign rd_addr_o = addr;

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe_o) && !$past(start_p || stop_p)) |-> !scl_s); // R11
    AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV && byte_done && mem_busy_i) |=> !sda_oe_o); // R3
    AST_WR_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> sda_oe_o); // R4
    AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |=> !sda_oe_o); // R1
    AST_END_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_end_o |-> (state == ST_IDLE)); // R6
endmodule

// File: tb/test_ees_slave.sv
module test_ees_slave;
    localparam int HP = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        mem_busy = 1'b0;
    logic        sda_oe;
    logic [10:0] rd_addr;
    logic [7:0]  rd_data;
    logic        wr_valid;
    logic [10:0] wr_addr;
    logic [7:0]  wr_data;
    logic        wr_end;
    logic        sda_line;

    logic [7:0]  store   [0:2047];
    logic [7:0]  ref_mem [0:2047];
    logic [10:0] wlog_a [0:15];
    logic [7:0]  wlog_d [0:15];
    logic [7:0]  wbuf   [0:15];
    int          wn = 0;
    int          end_cnt = 0;
    int          viol = 0;
    int          n_run = 0;
    int          n_fail = 0;
    int          ack_lat = 0;
    logic        oe_prev = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign rd_data  = store[rd_addr];

    ees_slave i_ees_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_oe_o   (sda_oe),
        .mem_busy_i (mem_busy),
        .rd_addr_o  (rd_addr),
        .rd_data_i  (rd_data),
        .wr_valid_o (wr_valid),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data),
        .wr_end_o   (wr_end)
    );

    always @(negedge clk) begin
        if (rst_n && wr_valid) begin
            store[wr_addr] = wr_data;
            if (wn < 16) begin
                wlog_a[wn] = wr_addr;
                wlog_d[wn] = wr_data;
            end
            wn++;
        end
        if (rst_n && wr_end) end_cnt++;
        if (rst_n && scl_m && sda_oe != oe_prev) viol++;
        oe_prev = sda_oe;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hw();
        repeat (HP) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; hw(); scl_m = 1'b1; hw(); sda_m = 1'b0; hw(); scl_m = 1'b0; hw();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; hw(); scl_m = 1'b1; hw(); sda_m = 1'b1; hw();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hw(); scl_m = 1'b1; hw(); scl_m = 1'b0;
            if (i == 0) begin
                ack_lat = 0;
                for (int k = 1; k <= HP; k++) begin
                    @(negedge clk);
                    if (sda_oe && ack_lat == 0) ack_lat = k;
                end
            end else begin
                hw();
            end
        end
        sda_m = 1'b1; scl_m = 1'b1;
        repeat (HP/2) @(negedge clk);
        ack = !sda_line;
        repeat (HP/2) @(negedge clk);
        scl_m = 1'b0; hw();
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit give_ack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hw(); scl_m = 1'b1;
            repeat (HP/2) @(negedge clk);
            b[i] = sda_line;
            repeat (HP/2) @(negedge clk);
            scl_m = 1'b0;
        end
        hw(); sda_m = give_ack ? 1'b0 : 1'b1; hw();
        scl_m = 1'b1; hw(); scl_m = 1'b0; hw(); sda_m = 1'b1;
    endtask

    function automatic logic [7:0] sel(input logic [10:0] a, input bit rd);
        return {4'b1010, a[10:8], rd};
    endfunction

    task automatic do_write(input logic [10:0] a, input int n);
        logic ack;
        int   e0;
        wn = 0;
        e0 = end_cnt;
        i2c_start();
        send_byte(sel(a, 1'b0), ack); chk(ack, "R4 select ack", ack, 1);
        send_byte(a[7:0], ack);       chk(ack, "R4 word ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ack);  chk(ack, "R4 data ack", ack, 1);
            ref_mem[11'(a + 11'(i))] = wbuf[i];
        end
        i2c_stop(); hw();
        chk(wn == n, "R5 strobe count", wn, n);
        for (int i = 0; i < n; i++) begin
            chk(wlog_a[i] == 11'(a + 11'(i)), "R5 R8 strobe addr", wlog_a[i], 11'(a + 11'(i)));
            chk(wlog_d[i] == wbuf[i], "R5 strobe data", wlog_d[i], wbuf[i]);
        end
        chk(end_cnt == e0 + 1, "R6 end pulse", end_cnt - e0, 1);
    endtask

    task automatic do_rread(input logic [10:0] a, input int n);
        logic       ack;
        logic [7:0] b;
        i2c_start();
        send_byte(sel(a, 1'b0), ack);
        send_byte(a[7:0], ack);
        i2c_start();
        send_byte(sel(a, 1'b1), ack); chk(ack, "R7 read select ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(b, i != n - 1);
            chk(b == ref_mem[11'(a + 11'(i))], "R7 R8 read data", b, ref_mem[11'(a + 11'(i))]);
        end
        i2c_stop();
    endtask

    initial begin
        logic       ack;
        logic [7:0] b;
        for (int i = 0; i < 2048; i++) begin
            store[i] = 8'h00;
            ref_mem[i] = 8'h00;
        end
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sda_oe == 1'b0, "R11 reset oe", sda_oe, 0);
        chk(wr_valid == 1'b0, "R11 reset strobe", wr_valid, 0);

        // R2: wrong device code
        i2c_start();
        send_byte(8'h90, ack); chk(!ack, "R2 wrong code", ack, 0);
        send_byte(8'hA0, ack); chk(!ack, "R2 ignored after mismatch", ack, 0);
        i2c_stop();

        // R1: byte after stop without start
        send_byte(8'hA0, ack); chk(!ack, "R1 no start", ack, 0);
        i2c_stop();

        // R3: busy polling
        mem_busy = 1'b1;
        i2c_start(); send_byte(8'hA0, ack); chk(!ack, "R3 busy nack", ack, 0); i2c_stop();
        mem_busy = 1'b0;
        i2c_start(); send_byte(8'hA0, ack); chk(ack, "R3 ack returns", ack, 1);
        chk(ack_lat == 3, "R12 ack latency", ack_lat, 3);
        i2c_stop();

        // directed write and read back
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h93;
        do_write(11'h345, 3);
        do_rread(11'h345, 3);

        // wrap across the top of the array
        wbuf[0] = 8'hA5; wbuf[1] = 8'h5A; wbuf[2] = 8'h3C;
        do_write(11'h7FF, 3);
        do_rread(11'h7FF, 2);

        // R10: current-address read continues at 0x001
        i2c_start();
        send_byte(8'hA1, ack); chk(ack, "R10 select ack", ack, 1);
        recv_byte(b, 1'b0);
        chk(b == ref_mem[1], "R10 current read", b, ref_mem[1]);
        // R9: after nack, the block stays off the line
        recv_byte(b, 1'b0);
        chk(b == 8'hFF, "R9 released after nack", b, 8'hFF);
        i2c_stop();
        i2c_start();
        send_byte(8'hA1, ack);
        recv_byte(b, 1'b0);
        chk(b == ref_mem[2], "R10 counter held", b, ref_mem[2]);
        i2c_stop();

        // random transfers
        void'($urandom(32'd4711));
        for (int it = 0; it < 8; it++) begin
            logic [10:0] a;
            int          n;
            a = 11'($urandom());
            n = 1 + int'($urandom() % 4);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom());
            do_write(a, n);
            do_rread(a, n);
        end

        chk(viol == 0, "R11 oe change while SCL high", viol, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule